// File: doc/BRIEF.md
# Victim-Buffered Direct-Mapped Read Cache

This block is a read-only cache. A direct-mapped main array of eight 16-byte lines sits in front of memory. A small fully associative victim buffer backs the main array and holds lines that were recently pushed out of it. Each request carries an 8-bit byte address and returns one 32-bit word. The response is tagged with one of three outcomes:

- a main-array hit;
- a victim-buffer hit, in which the buffered line is exchanged with the line occupying its main slot;
- a full miss, which reads the whole line from memory over a fixed number of cycles.

When a full miss replaces a valid main line, the displaced line goes into the victim buffer. The buffer slot it takes is chosen by a first-in first-out pointer, so the oldest buffered line is dropped once the buffer is full. The requester presents one request at a time. It may issue a new request whenever the ready output is high.

Top module: `victim_dm_cache`

## Requirements
- R1: After reset every main line and every victim entry is invalid, `reqReady` is 1, and `respValid` and `memRd` are 0. The first access to any line is therefore a full miss.
- R2: Address bit 7 is the line tag, bits 6:4 are the main index, bits 3:2 select the word and bits 1:0 are ignored. Word w of a line is bits [32w+31:32w] of the 128-bit memory line.
- R3: A main-array hit raises `respValid` with `respHit` and the addressed word in the cycle after the request is accepted.
- R4: A main miss that matches a victim entry raises `respValid` with `respVictHit` two cycles after acceptance. The victim line then occupies the main slot, and the line that was in the main slot occupies the victim entry that hit.
- R5: On a full miss, `memRd` stays high with `memLine` = {tag,index} for REFILL_LAT cycles. `respValid` with `respMiss` and the word taken from `memData` follow REFILL_LAT+1 cycles after acceptance.
- R6: On a full miss whose main slot holds a valid line, that line is written into the victim entry named by the FIFO pointer, and the pointer then advances by one (wrapping). Any line already in that entry is dropped.
- R7: After a victim-hit exchange, the FIFO pointer names the entry following the one that hit. The line just moved into the buffer is therefore the last to be replaced.
- R8: On a full miss whose main slot is invalid, the victim buffer and its pointer are left unchanged.
- R9: Whenever `respValid` is 1, exactly one of `respHit`, `respVictHit`, `respMiss` is 1. All three are 0 while `respValid` is 0.
- R10: `reqReady` is 0 while an exchange or a refill is in progress. A `reqValid` pulse during that time is ignored and changes no cache state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | 8 | Byte address of the requested word |
| reqReady | output | 1 | Block can accept a request this cycle |
| respValid | output | 1 | One-cycle response strobe |
| respHit | output | 1 | Response came from the main array |
| respVictHit | output | 1 | Response came from the victim buffer |
| respMiss | output | 1 | Response came from a memory refill |
| respData | output | 32 | Returned word |
| memRd | output | 1 | Refill read in progress |
| memLine | output | 4 | Line address {tag,index} being refilled |
| memData | input | 128 | Line returned by memory, sampled on the last refill cycle |

## Verification
Two updates can land on the same clock edge. On a victim hit, the main slot and the hit victim entry are overwritten together, while the FIFO pointer is moved. On a full miss, the refilled line enters the main array while the displaced line overwrites the oldest victim entry. The bench provokes both with traces that ping-pong two lines sharing one index, and with traces that fill more distinct indices than the buffer holds, so that evictions and exchanges interleave. Each access is judged against a behavioural model of both arrays and the pointer. The model predicts the outcome kind, the response cycle and the word. A later access to the line that was moved or dropped exposes any update that was lost or mis-targeted.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  parameter int ADDR_W     = 8;
  parameter int BYTE_W     = 2;
  parameter int WORD_W     = 32;
  parameter int LINE_WORDS = 4;
  parameter int MAIN_LINES = 8;

  localparam int WSEL_W    = $clog2(LINE_WORDS);
  localparam int IDX_W     = $clog2(MAIN_LINES);
  localparam int WADDR_W   = ADDR_W - BYTE_W;
  localparam int TAG_W     = WADDR_W - IDX_W - WSEL_W;
  localparam int LINEA_W   = TAG_W + IDX_W;
  localparam int LINE_BITS = WORD_W * LINE_WORDS;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // accept request address this cycle
    logic respMain;  // answer from main array
    logic doSwap;    // exchange main slot with matching victim entry
    logic doRefill;  // write memory line, push displaced line
  } vcCtl_t;

  // lookup result from datapath to control
  typedef struct packed {
    logic mainHit;
    logic victHit;
  } vcLook_t;
endpackage

// File: rtl/vc_victim_buf.sv
module vc_victim_buf import vcache_pkg::*; #(
  parameter int ENTRIES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LINEA_W-1:0]   lookLine,
  output logic                 hit,
  output logic [LINE_BITS-1:0] hitData,
  input  logic                 wrEn,
  input  logic                 swapMode,
  input  logic                 wrValid,
  input  logic [LINEA_W-1:0]   wrLine,
  input  logic [LINE_BITS-1:0] wrData
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]   entValid;
  logic [ENTRIES-1:0]   match;
  logic [LINEA_W-1:0]   entLine [ENTRIES];
  logic [LINE_BITS-1:0] entData [ENTRIES];
  logic [PTR_W-1:0]     fifoPtr;
  logic [PTR_W-1:0]     hitSlot;
  logic [PTR_W-1:0]     wrSlot;
  logic [PTR_W-1:0]     nextSlot;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = entValid[e] && (entLine[e] == lookLine);
    end
  endgenerate

  always_comb begin
    hitSlot = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) hitSlot = PTR_W'(e);
    end
  end

  assign hit      = |match;
  assign hitData  = entData[hitSlot];
  // an exchange reuses the matching slot; a refill push uses the FIFO slot
  assign wrSlot   = swapMode ? hitSlot : fifoPtr;
  assign nextSlot = (wrSlot == PTR_W'(ENTRIES - 1)) ? '0 : wrSlot + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      fifoPtr  <= '0;
    end else if (wrEn) begin
      entValid[wrSlot] <= wrValid;
      fifoPtr          <= nextSlot;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      entLine[wrSlot] <= wrLine;
      entData[wrSlot] <= wrData;
    end
  end
endmodule

// File: rtl/vc_datapath.sv
module vc_datapath import vcache_pkg::*; #(
  parameter int VICT_ENTRIES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vcCtl_t               ctl,
  input  logic [WADDR_W-1:0]   reqWord,
  input  logic [LINE_BITS-1:0] memData,
  output vcLook_t              look,
  output logic [LINEA_W-1:0]   memLine,
  output logic                 respValid,
  output logic                 respHit,
  output logic                 respVictHit,
  output logic                 respMiss,
  output logic [WORD_W-1:0]    respData
);
  logic [WADDR_W-1:0]   curAddr;
  logic [WADDR_W-1:0]   lookAddr;
  logic [TAG_W-1:0]     lkTag;
  logic [IDX_W-1:0]     lkIdx;
  logic [WSEL_W-1:0]    lkWord;

  logic [MAIN_LINES-1:0] mainValid;
  logic [TAG_W-1:0]      mainTag  [MAIN_LINES];
  logic [LINE_BITS-1:0]  mainData [MAIN_LINES];

  logic                 vbHit;
  logic [LINE_BITS-1:0] vbData;
  logic                 vbWrEn;
  logic                 mainHitNow;

  function automatic logic [WORD_W-1:0] pickWord(input logic [LINE_BITS-1:0] ln,
                                                  input logic [WSEL_W-1:0] w);
    return ln[w*WORD_W +: WORD_W];
  endfunction

  assign lookAddr   = ctl.capture ? reqWord : curAddr;
  assign lkTag      = lookAddr[WADDR_W-1 -: TAG_W];
  assign lkIdx      = lookAddr[WSEL_W +: IDX_W];
  assign lkWord     = lookAddr[WSEL_W-1:0];
  assign mainHitNow = mainValid[lkIdx] && (mainTag[lkIdx] == lkTag);

  assign look.mainHit = mainHitNow;
  assign look.victHit = vbHit && !mainHitNow;
  assign memLine      = curAddr[WADDR_W-1:WSEL_W];

  // displaced line goes back to the buffer on exchange, or on refill if valid
  assign vbWrEn = ctl.doSwap || (ctl.doRefill && mainValid[lkIdx]);

  vc_victim_buf #(.ENTRIES(VICT_ENTRIES)) u_vbuf (
    .clk      (clk),
    .rstN     (rstN),
    .lookLine ({lkTag, lkIdx}),
    .hit      (vbHit),
    .hitData  (vbData),
    .wrEn     (vbWrEn),
    .swapMode (ctl.doSwap),
    .wrValid  (mainValid[lkIdx]),
    .wrLine   ({mainTag[lkIdx], lkIdx}),
    .wrData   (mainData[lkIdx])
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (ctl.capture) begin
      curAddr <= reqWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainValid <= '0;
    end else if (ctl.doSwap || ctl.doRefill) begin
      mainValid[lkIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.doSwap) begin
      mainTag[lkIdx]  <= lkTag;
      mainData[lkIdx] <= vbData;
    end else if (ctl.doRefill) begin
      mainTag[lkIdx]  <= lkTag;
      mainData[lkIdx] <= memData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respVictHit <= 1'b0;
      respMiss    <= 1'b0;
      respData    <= '0;
    end else begin
      respValid   <= ctl.respMain || ctl.doSwap || ctl.doRefill;
      respHit     <= ctl.respMain;
      respVictHit <= ctl.doSwap;
      respMiss    <= ctl.doRefill;
      if (ctl.respMain)      respData <= pickWord(mainData[lkIdx], lkWord);
      else if (ctl.doSwap)   respData <= pickWord(vbData, lkWord);
      else if (ctl.doRefill) respData <= pickWord(memData, lkWord);
    end
  end
endmodule

// File: rtl/vc_control.sv
module vc_control import vcache_pkg::*; #(
  parameter int REFILL_LAT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  vcLook_t look,
  output vcCtl_t  ctl,
  output logic    reqReady,
  output logic    memRd
);
  localparam int CNT_W = (REFILL_LAT > 1) ? $clog2(REFILL_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFILL_LAT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SWAP, ST_REFILL} vcState_e;

  vcState_e        state;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    ctl          = '0;
    reqReady     = (state == ST_IDLE);
    memRd        = (state == ST_REFILL);
    case (state)
      ST_IDLE: begin
        ctl.capture  = reqValid;
        ctl.respMain = reqValid && look.mainHit;
      end
      ST_SWAP:   ctl.doSwap   = 1'b1;
      ST_REFILL: ctl.doRefill = (waitCnt == CNT_LAST);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (reqValid && !look.mainHit) begin
            state <= look.victHit ? ST_SWAP : ST_REFILL;
          end
        end
        ST_SWAP: state <= ST_IDLE;
        ST_REFILL: begin
          if (waitCnt == CNT_LAST) state <= ST_IDLE;
          else waitCnt <= waitCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/victim_dm_cache.sv
module victim_dm_cache import vcache_pkg::*; #(
  parameter int VICT_ENTRIES = 2,
  parameter int REFILL_LAT   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 reqReady,
  output logic                 respValid,
  output logic                 respHit,
  output logic                 respVictHit,
  output logic                 respMiss,
  output logic [WORD_W-1:0]    respData,
  output logic                 memRd,
  output logic [LINEA_W-1:0]   memLine,
  input  logic [LINE_BITS-1:0] memData
);
  vcCtl_t  ctl;
  vcLook_t look;
  logic [BYTE_W-1:0] unusedByteSel;

  assign unusedByteSel = reqAddr[BYTE_W-1:0];

  vc_control #(.REFILL_LAT(REFILL_LAT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .look     (look),
    .ctl      (ctl),
    .reqReady (reqReady),
    .memRd    (memRd)
  );

  vc_datapath #(.VICT_ENTRIES(VICT_ENTRIES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqWord     (reqAddr[ADDR_W-1:BYTE_W]),
    .memData     (memData),
    .look        (look),
    .memLine     (memLine),
    .respValid   (respValid),
    .respHit     (respHit),
    .respVictHit (respVictHit),
    .respMiss    (respMiss),
    .respData    (respData)
  );
endmodule

// File: rtl/vc_checker.sv
module vc_checker import vcache_pkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               respValid,
  input logic               respHit,
  input logic               respVictHit,
  input logic               respMiss,
  input logic               memRd,
  input logic [LINEA_W-1:0] memLine
);
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot({respHit, respVictHit, respMiss})); // R9
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> ({respHit, respVictHit, respMiss} == 3'b000)); // R9
  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> $past(reqValid && reqReady)); // R3
  AST_VHIT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    respVictHit |-> $past(reqValid && reqReady, 2)); // R4
  AST_MISS_AFTER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> $past(memRd)); // R5
  AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> $stable(memLine)); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !reqReady); // R10
endmodule

bind victim_dm_cache vc_checker u_vc_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .respValid   (respValid),
  .respHit     (respHit),
  .respVictHit (respVictHit),
  .respMiss    (respMiss),
  .memRd       (memRd),
  .memLine     (memLine)
);

// File: tb/sim_victim_dm_cache.sv
module sim_victim_dm_cache;
  localparam int CLK_PERIOD = 10;
  localparam int REFILL_LAT = 4;
  localparam int NVICT      = 2;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic [7:0]   reqAddr;
  logic         reqReady;
  logic         respValid, respHit, respVictHit, respMiss;
  logic [31:0]  respData;
  logic         memRd;
  logic [3:0]   memLine;
  logic [127:0] memData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  int mV[8];
  int mT[8];
  int vV[NVICT];
  int vL[NVICT];
  int vPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] wordOf(input logic [3:0] la, input int w);
    return {4'hD, la, 8'h5A, 8'(w), 8'(la * 8'd9 + 8'(w))};
  endfunction

  function automatic logic [127:0] lineOf(input logic [3:0] la);
    logic [127:0] ln;
    for (int w = 0; w < 4; w++) ln[w*32 +: 32] = wordOf(la, w);
    return ln;
  endfunction

  assign memData = lineOf(memLine);

  victim_dm_cache #(.VICT_ENTRIES(NVICT), .REFILL_LAT(REFILL_LAT)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respHit(respHit),
    .respVictHit(respVictHit), .respMiss(respMiss), .respData(respData),
    .memRd(memRd), .memLine(memLine), .memData(memData)
  );

  task automatic chk(input string req, input logic ok, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // model: returns kind (0 hit, 1 victim hit, 2 miss) and updates state
  function automatic int modelAccess(input logic [7:0] a);
    int tag = int'(a[7]);
    int idx = int'(a[6:4]);
    int la  = int'(a[7:4]);
    if (mV[idx] != 0 && mT[idx] == tag) return 0;
    for (int s = 0; s < NVICT; s++) begin
      if (vV[s] != 0 && vL[s] == la) begin
        vV[s] = mV[idx];
        vL[s] = mT[idx] * 8 + idx;
        mV[idx] = 1;
        mT[idx] = tag;
        vPtr = (s + 1) % NVICT;
        return 1;
      end
    end
    if (mV[idx] != 0) begin
      vV[vPtr] = 1;
      vL[vPtr] = mT[idx] * 8 + idx;
      vPtr = (vPtr + 1) % NVICT;
    end
    mV[idx] = 1;
    mT[idx] = tag;
    return 2;
  endfunction

  task automatic access(input logic [7:0] a, input string tag,
                        input bit poke = 0, input logic [7:0] pokeAddr = 8'h00);
    int kind;
    int lat;
    logic [2:0] expFlags;
    string kTag;
    while (!reqReady) @(negedge clk);
    kind = modelAccess(a);
    lat  = (kind == 0) ? 1 : (kind == 1) ? 2 : REFILL_LAT + 1;
    expFlags = (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
    kTag = (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5";
    reqValid = 1'b1;
    reqAddr  = a;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      if (c == 1) begin
        reqValid = 1'b0;
        if (kind == 2) begin
          chk("R5", memRd === 1'b1 && memLine === a[7:4], "refill request",
              int'({memRd, memLine}), int'({1'b1, a[7:4]}));
          chk("R10", reqReady === 1'b0, "ready during refill", int'(reqReady), 0);
          if (poke) begin
            reqValid = 1'b1;
            reqAddr  = pokeAddr;
          end
        end
      end
      if (c == 2) reqValid = 1'b0;
      if (c < lat) begin
        chk({kTag, "/R9"}, {respValid, respHit, respVictHit, respMiss} === 4'b0000,
            "early response", int'({respValid, respHit, respVictHit, respMiss}), 0);
      end else begin
        chk({kTag, "/", tag}, respValid === 1'b1 && {respHit, respVictHit, respMiss} === expFlags,
            $sformatf("kind at %02h", a), int'({respValid, respHit, respVictHit, respMiss}),
            int'({1'b1, expFlags}));
        chk("R2", respData === wordOf(a[7:4], int'(a[3:2])),
            $sformatf("data at %02h", a), int'(respData), int'(wordOf(a[7:4], int'(a[3:2]))));
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mV[i] = 0; mT[i] = 0; end
    for (int s = 0; s < NVICT; s++) begin vV[s] = 0; vL[s] = 0; end
    vPtr = 0;
    rstN = 1'b0;
    reqValid = 1'b0;
    reqAddr = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", reqReady === 1'b1, "ready after reset", int'(reqReady), 1);
    chk("R1", respValid === 1'b0 && memRd === 1'b0, "idle outputs after reset",
        int'({respValid, memRd}), 0);

    access(8'h00, "R1");
    access(8'h04, "R3");
    access(8'h0B, "R2");
    access(8'h0C, "R2");
    access(8'h80, "R6");   // evicts line 0 into the buffer
    access(8'h08, "R4");   // exchange back
    access(8'h00, "R3");
    access(8'h84, "R4");   // line 8 returns from the buffer
    access(8'h10, "R8");   // empty slot: buffer untouched
    access(8'h94, "R6");
    access(8'h88, "R3");
    access(8'h14, "R7");
    access(8'hA0, "R8");
    access(8'h20, "R6");   // buffer full: oldest dropped
    access(8'hB0, "R8");
    access(8'h30, "R6");
    access(8'h00, "R6");
    access(8'h98, "R7");
    access(8'h90, "R7");
    access(8'hA8, "R6");
    // request during a refill must be ignored
    access(8'hC4, "R10", 1'b1, 8'h54);
    access(8'h54, "R10");
    access(8'h44, "R7");
    // interleaved trace over all indices and both tags
    for (int i = 0; i < 48; i++) begin
      access(8'((i * 37 + 11) & 8'hFF), "R2");
    end
    for (int i = 0; i < 12; i++) begin
      access(8'((i % 2 == 0) ? 8'h60 : 8'hE0), "R4");
      access(8'((i % 3) * 16 + 8'h60 + 4 * (i % 4)), "R6");
    end
    repeat (3) @(negedge clk);
    chk("R9", respValid === 1'b0, "quiet when idle", int'(respValid), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule